// File: doc/BRIEF.md
# Paged Controller Address Translator

This block sits between a network controller and a board's local RAM. The controller issues 24-bit addresses. The block looks up the page that each address falls in within a host-programmable page map and returns the physical RAM address. It also reports where that memory lives (on the board or on an auxiliary bus) and whether the 16-bit data path must be byte-swapped. Pages are 1024 bytes and the map has 1024 slots, so only the low 20 address bits take part in the lookup.

The host programs and reads the map one 16-bit entry at a time through a small register port. Each entry holds a page frame number, a location bit and a byte-order bit. Several slots may name the same frame. This lets the controller find its fixed boot pointer near the top of the address space in the same RAM page that also appears at address zero. Translation results are registered and appear one cycle after the request, together with the lane-corrected write data and byte enables.

Top module: `pgxl_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_valid` and `host_rvalid` are low.
- R2: A host write with `host_we` stores `host_wdata` in slot `host_slot` from the next cycle on. A host read with `host_re` returns that slot's entry on `host_rdata` one cycle later, with `host_rvalid` high for that cycle only. All 16 bits read back as written.
- R3: Controller address bits 23..20 have no effect on any output. Bits 19..10 pick the map slot and bits 9..0 are the byte offset in the page.
- R4: A request with `ctl_req` high gives `mem_valid` high one cycle later, with `mem_addr` = {entry bits 11..0, offset}. With no request, `mem_valid` is low one cycle later.
- R5: `mem_aux` equals bit 13 of the selected entry (1 = auxiliary bus, 0 = on-board).
- R6: `mem_swap` equals bit 15 of the selected entry. When it is 1, the two bytes of `ctl_wdata` and the two bits of `ctl_be` are exchanged on `mem_wdata`/`mem_be`. When it is 0, they pass through unchanged.
- R7: `mem_oor` is 1 exactly when the entry's frame is 256 or more and bit 13 is 0 (the board has 256 frames only).
- R8: Address 0xFFFFF4 translates through slot 1023. Two slots that hold the same frame give the same physical address for the same offset.
- R9: A translation requested in the same cycle as a host write to its own slot uses the entry from before that write. The next request uses the new entry.
- R10: A host read in the same cycle as a host write to the same slot returns the entry from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host map-entry write strobe |
| host_re | input | 1 | Host map-entry read strobe |
| host_slot | input | 10 | Map slot addressed by the host |
| host_wdata | input | 16 | Entry value to store |
| host_rdata | output | 16 | Entry value read back |
| host_rvalid | output | 1 | Read data valid |
| ctl_req | input | 1 | Controller access request |
| ctl_addr | input | 24 | Controller byte address |
| ctl_be | input | 2 | Controller byte-lane enables |
| ctl_wdata | input | 16 | Controller write data |
| mem_valid | output | 1 | Translated access valid |
| mem_addr | output | 22 | Physical address {frame, offset} |
| mem_be | output | 2 | Lane-corrected byte enables |
| mem_wdata | output | 16 | Lane-corrected write data |
| mem_aux | output | 1 | Memory is on the auxiliary bus |
| mem_swap | output | 1 | Lanes are swapped for this page |
| mem_oor | output | 1 | Frame has no on-board backing |

## Verification
A corrupted map entry shows up one cycle after the next translation of that slot, as a wrong frame in `mem_addr` or as wrong `mem_swap`, `mem_aux` or `mem_oor` flags. It also shows up one cycle after a host read of the slot. A slot decoded from the wrong address bits moves every translation to an unrelated frame. This is exposed by addresses whose upper nibble differs and by the aliased top slot. A write that lands a cycle too early is caught by a translation or read issued in the same cycle as the write.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;
    localparam int CTL_AW        = 24;
    localparam int SLOT_W        = 10;
    localparam int OFS_W         = 10;
    localparam int FRAME_W       = 12;
    localparam int LANES         = 2;
    localparam int ENTRY_W       = 16;
    localparam int ONBOARD_PAGES = 256;
    localparam int SLOTS         = 1 << SLOT_W;
    localparam int PHYS_W        = FRAME_W + OFS_W;
    localparam int DATA_W        = 8 * LANES;
    localparam int SLOT_LSB      = OFS_W;
    localparam int SLOT_MSB      = OFS_W + SLOT_W - 1;

    typedef struct packed {
        logic               big_end;
        logic               rsv14;
        logic               on_aux;
        logic               rsv12;
        logic [FRAME_W-1:0] frame;
    } map_entry_t;

    typedef struct packed {
        logic              valid;
        logic [PHYS_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
        logic              aux;
        logic              swap;
        logic              oor;
    } xlate_out_t;

    function automatic logic frame_unbacked(map_entry_t e);
        return !e.on_aux && (int'(e.frame) >= ONBOARD_PAGES);
    endfunction
endpackage

// File: rtl/pgxl_map_store.sv
module pgxl_map_store
    import pgxl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [SLOT_W-1:0]  host_slot,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rd_valid,
    input  logic [SLOT_W-1:0]  lk_slot,
    output map_entry_t         lk_entry
);
    logic [ENTRY_W-1:0] table_q [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            table_q[host_slot] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= table_q[host_slot];
            end
        end
    end

    assign lk_entry = map_entry_t'(table_q[lk_slot]);

    p_rvalid_follows_re_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    p_rvalid_single_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/pgxl_lane_swap.sv
module pgxl_lane_swap
    import pgxl_pkg::*;
(
    input  logic              swap,
    input  logic [LANES-1:0]  be_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [LANES-1:0]  be_out,
    output logic [DATA_W-1:0] data_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int MIR = LANES - 1 - g;
        assign be_out[g]         = swap ? be_in[MIR]         : be_in[g];
        assign data_out[g*8 +: 8] = swap ? data_in[MIR*8 +: 8] : data_in[g*8 +: 8];
    end
endmodule

// File: rtl/pgxl_xlate.sv
module pgxl_xlate
    import pgxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CTL_AW-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  map_entry_t        entry,
    output xlate_out_t        result
);
    logic [LANES-1:0]  be_fix;
    logic [DATA_W-1:0] data_fix;
    xlate_out_t        nxt;
    logic              unused_bits;

    assign unused_bits = ^{addr[CTL_AW-1:SLOT_MSB+1], addr[SLOT_MSB:SLOT_LSB],
                           entry.rsv14, entry.rsv12};

    pgxl_lane_swap u_swap (
        .swap    (entry.big_end),
        .be_in   (be),
        .data_in (wdata),
        .be_out  (be_fix),
        .data_out(data_fix)
    );

    always_comb begin
        nxt       = '0;
        nxt.valid = req;
        nxt.addr  = {entry.frame, addr[OFS_W-1:0]};
        nxt.be    = be_fix;
        nxt.data  = data_fix;
        nxt.aux   = entry.on_aux;
        nxt.swap  = entry.big_end;
        nxt.oor   = frame_unbacked(entry);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (req) begin
            result <= nxt;
        end else begin
            result.valid <= 1'b0;
        end
    end

    p_valid_after_req_r4: assert property (@(posedge clk) disable iff (rst)
        req |=> result.valid);
    p_idle_after_noreq_r4: assert property (@(posedge clk) disable iff (rst)
        !req |=> !result.valid);
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
        req |=> result.addr[OFS_W-1:0] == $past(addr[OFS_W-1:0]));
    p_oor_only_onboard_r7: assert property (@(posedge clk) disable iff (rst)
        result.valid && result.oor |-> !result.aux);
    p_straight_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        req && !entry.big_end |=> result.be == $past(be));
endmodule

// File: rtl/pgxl_top.sv
module pgxl_top
    import pgxl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [SLOT_W-1:0]  host_slot,
    input  logic [ENTRY_W-1:0] host_wdata,
    output logic [ENTRY_W-1:0] host_rdata,
    output logic               host_rvalid,
    input  logic               ctl_req,
    input  logic [CTL_AW-1:0]  ctl_addr,
    input  logic [LANES-1:0]   ctl_be,
    input  logic [DATA_W-1:0]  ctl_wdata,
    output logic               mem_valid,
    output logic [PHYS_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_aux,
    output logic               mem_swap,
    output logic               mem_oor
);
    map_entry_t cur_entry;
    xlate_out_t res;

    pgxl_map_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_we),
        .rd_en    (host_re),
        .host_slot(host_slot),
        .wr_data  (host_wdata),
        .rd_data  (host_rdata),
        .rd_valid (host_rvalid),
        .lk_slot  (ctl_addr[SLOT_MSB:SLOT_LSB]),
        .lk_entry (cur_entry)
    );

    pgxl_xlate u_xlate (
        .clk   (clk),
        .rst   (rst),
        .req   (ctl_req),
        .addr  (ctl_addr),
        .be    (ctl_be),
        .wdata (ctl_wdata),
        .entry (cur_entry),
        .result(res)
    );

    assign mem_valid = res.valid;
    assign mem_addr  = res.addr;
    assign mem_be    = res.be;
    assign mem_wdata = res.data;
    assign mem_aux   = res.aux;
    assign mem_swap  = res.swap;
    assign mem_oor   = res.oor;

    p_backed_frame_range_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_oor && !mem_aux |-> mem_addr[PHYS_W-1:OFS_W+8] == '0);
    p_swap_exchanges_be_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_swap |-> $countones(mem_be) == $countones($past(ctl_be)));
endmodule

// File: tb/pgxl_top_tb.sv
module pgxl_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_we, host_re;
    logic [9:0]  host_slot;
    logic [15:0] host_wdata, host_rdata;
    logic        host_rvalid;
    logic        ctl_req;
    logic [23:0] ctl_addr;
    logic [1:0]  ctl_be;
    logic [15:0] ctl_wdata;
    logic        mem_valid;
    logic [21:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic        mem_aux, mem_swap, mem_oor;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [15:0] shadow [1024];

    always #4 clk = ~clk;

    pgxl_top u_dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_we = 0; host_re = 0; ctl_req = 0;
    endtask

    task automatic map_write(logic [9:0] slot, logic [15:0] val);
        host_we = 1; host_slot = slot; host_wdata = val;
        step();
        host_we = 0;
        shadow[slot] = val;
    endtask

    task automatic map_read_check(string req, logic [9:0] slot);
        host_re = 1; host_slot = slot;
        step();
        host_re = 0;
        chk(req, {31'd0, host_rvalid}, 32'd1);
        chk(req, {16'd0, host_rdata}, {16'd0, shadow[slot]});
        step();
        chk(req, {31'd0, host_rvalid}, 32'd0);
    endtask

    task automatic xlate_check(string req, logic [23:0] a, logic [1:0] be, logic [15:0] d);
        logic [15:0] e;
        logic        sw;
        e = shadow[a[19:10]];
        sw = e[15];
        ctl_req = 1; ctl_addr = a; ctl_be = be; ctl_wdata = d;
        step();
        ctl_req = 0;
        chk(req, {31'd0, mem_valid}, 32'd1);
        chk(req, {10'd0, mem_addr}, {10'd0, e[11:0], a[9:0]});
        chk(req, {31'd0, mem_aux}, {31'd0, e[13]});
        chk(req, {31'd0, mem_swap}, {31'd0, sw});
        chk(req, {31'd0, mem_oor}, {31'd0, (!e[13] && e[11:0] >= 12'd256)});
        chk(req, {30'd0, mem_be}, {30'd0, sw ? {be[0], be[1]} : be});
        chk(req, {16'd0, mem_wdata}, {16'd0, sw ? {d[7:0], d[15:8]} : d});
    endtask

    task automatic t_reset();
        rst = 1; idle(); host_slot = 0; host_wdata = 0;
        ctl_addr = 0; ctl_be = 0; ctl_wdata = 0;
        step(); step();
        chk("R1 reset", {30'd0, mem_valid, host_rvalid}, 32'd0);
        rst = 0;
        step();
        chk("R1 after reset", {30'd0, mem_valid, host_rvalid}, 32'd0);
    endtask

    task automatic t_host_port();
        map_write(10'd3, 16'h5ABC);
        map_read_check("R2 readback", 10'd3);
        map_write(10'd700, 16'hFFFF);
        map_read_check("R2 all bits", 10'd700);
    endtask

    task automatic t_basic();
        map_write(10'd1, 16'h0042);
        xlate_check("R4 straight map", 24'h0007FE, 2'b01, 16'h1234);
        step();
        chk("R4 no request", {31'd0, mem_valid}, 32'd0);
        map_write(10'd2, 16'h2123);
        xlate_check("R5 aux page", 24'h000811, 2'b11, 16'hA5C3);
    endtask

    task automatic t_upper_ignored();
        map_write(10'd9, 16'h00AA);
        xlate_check("R3 upper nibble 0", 24'h002455, 2'b10, 16'h0F0F);
        xlate_check("R3 upper nibble F", 24'hF02455, 2'b10, 16'h0F0F);
        xlate_check("R3 upper nibble 6", 24'h602455, 2'b10, 16'h0F0F);
    endtask

    task automatic t_swap();
        map_write(10'd4, 16'h8011);
        xlate_check("R6 swapped lanes", 24'h001002, 2'b01, 16'hBEEF);
        xlate_check("R6 swapped both", 24'h001004, 2'b11, 16'h1122);
        map_write(10'd4, 16'h0011);
        xlate_check("R6 straight lanes", 24'h001002, 2'b01, 16'hBEEF);
    endtask

    task automatic t_range();
        map_write(10'd5, 16'h0100);
        xlate_check("R7 frame 256 onboard", 24'h001400, 2'b11, 16'h0);
        map_write(10'd5, 16'h00FF);
        xlate_check("R7 frame 255 onboard", 24'h001400, 2'b11, 16'h0);
        map_write(10'd5, 16'h2FFF);
        xlate_check("R7 big frame on aux", 24'h001400, 2'b11, 16'h0);
    endtask

    task automatic t_alias();
        map_write(10'd0, 16'h8000);
        map_write(10'd1023, 16'h8000);
        xlate_check("R8 boot pointer top slot", 24'hFFFFF4, 2'b11, 16'h0102);
        chk("R8 top slot addr", {10'd0, mem_addr}, 32'h3F4);
        xlate_check("R8 alias slot 0", 24'h0003F4, 2'b11, 16'h0102);
        chk("R8 alias same addr", {10'd0, mem_addr}, 32'h3F4);
    endtask

    task automatic t_same_cycle();
        logic [15:0] old_v;
        map_write(10'd6, 16'h0033);
        old_v = shadow[6];
        host_we = 1; host_slot = 10'd6; host_wdata = 16'h8077;
        ctl_req = 1; ctl_addr = 24'h001823; ctl_be = 2'b01; ctl_wdata = 16'h1357;
        step();
        idle();
        chk("R9 old entry frame", {10'd0, mem_addr}, {10'd0, old_v[11:0], 10'h023});
        chk("R9 old entry swap", {31'd0, mem_swap}, {31'd0, old_v[15]});
        shadow[6] = 16'h8077;
        xlate_check("R9 new entry next", 24'h001823, 2'b01, 16'h1357);
        host_we = 1; host_re = 1; host_slot = 10'd6; host_wdata = 16'h0044;
        step();
        idle();
        chk("R10 read old on write", {16'd0, host_rdata}, 32'h8077);
        shadow[6] = 16'h0044;
        map_read_check("R10 new value after", 10'd6);
    endtask

    initial begin
        t_reset();
        t_host_port();
        t_basic();
        t_upper_ignored();
        t_swap();
        t_range();
        t_alias();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule